// File: doc/BRIEF.md
# Typed Address-Event Input Decoder

This block sits at the input edge of a time-multiplexed spiking core with N neurons. An external sender presents an address word and raises a request line that is not synchronous to the core clock. The block brings the request into the clock domain through a two-flop synchronizer and latches the address word. It then sorts the word into one of five event kinds and sends the core a typed command over a valid/ready port. The acknowledge line follows a four-phase protocol. It rises once the word has been taken and falls once the sender has withdrawn its request.

The address word is 1+2·log2(N) bits wide, which is 17 bits for the default of 256 neurons. Besides plain spike addresses, one word format can carry a single addressed synapse, a virtual synapse with an immediate weight, and two global timing strobes. The command register holds one entry. While a command waits for the core, no further word is acknowledged, so the sender is held back. A word whose code has no meaning is still acknowledged so that the bus keeps moving. It is discarded and sets an error flag that only reset clears.

Top module: `aer_event_decoder`

## Requirements
- R1: The acknowledge output rises only while the synchronized request is high and the address has been captured in that same cycle. It falls only after the synchronized request has gone low, and a new word is taken only after the acknowledge has fallen.
- R2: With no command pending, the acknowledge rises on the third rising clock edge after the request rises. It falls on the third rising clock edge after the request falls. The same third edge after the request rises also makes a decoded command valid.
- R3: If address bit 2·NW is 0 and bits [2·NW-1:NW] are all zero, the command is a spike (type 0). The source field is bits [NW-1:0], and the destination and weight fields are zero.
- R4: If address bit 2·NW is 1, the command is a single-synapse event (type 1). The source field is bits [2·NW-1:NW], the destination field is bits [NW-1:0], and the weight field is zero.
- R5: If address bit 2·NW is 0 and bits [2·NW-1:NW+3] equal 1, the command is a virtual-synapse event (type 2). The weight field is bits [NW+2:NW], the destination field is bits [NW-1:0], and the source field is zero.
- R6: If address bit 2·NW is 0, bits [2·NW-1:NW] are all ones and bits [NW-1:0] are zero, the command is a neuron time-reference event (type 3) with all fields zero.
- R7: If address bit 2·NW is 0, bits [2·NW-1:NW] equal all ones minus one and bits [NW-1:0] are zero, the command is a synapse bistability event (type 4) with all fields zero.
- R8: Any other word is acknowledged like a valid one but issues no command. It sets the error output, which stays high until reset whatever events follow.
- R9: While a command is valid and not accepted, its fields stay unchanged even if the address input changes, and a new request is not acknowledged. Once ready is seen high, the pending request is served.
- R10: After reset, acknowledge, command valid and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low reset |
| aer_req_i | input | 1 | Asynchronous request from the sender |
| aer_addr_i | input | 2·NW+1 | Address word, stable while request is high |
| aer_ack_o | output | 1 | Handshake acknowledge |
| cmd_valid_o | output | 1 | Command register holds an entry |
| cmd_ready_i | input | 1 | Core takes the command |
| cmd_type_o | output | 3 | Event kind, 0 to 4 |
| cmd_src_o | output | NW | Source neuron field |
| cmd_dst_o | output | NW | Destination neuron field |
| cmd_weight_o | output | 3 | Immediate weight field |
| err_o | output | 1 | Sticky flag for undefined codes |

## Verification
A table of words drives the decoder through each of the five kinds. It uses extreme field values: all-ones and all-zeros sources and destinations, and zero and non-zero weights. These cases separate swapped or shifted fields and a wrongly chosen kind. Two undefined words cover the cases that lie next to legal codes: an upper field just below the virtual prefix, and a time-reference upper code with a non-zero low byte. They show that the error flag sets, that no command appears and that a later legal word still decodes. A back-pressure sequence holds ready low and changes the address bus. It shows that a second request stays unacknowledged and the pending fields do not move. It then checks that the held request completes once ready is given.

// File: rtl/aer_dec_pkg.sv
package aer_dec_pkg;

    typedef enum logic [2:0] {
        CMD_SPIKE   = 3'd0,
        CMD_SYNAPSE = 3'd1,
        CMD_VIRTUAL = 3'd2,
        CMD_TREF    = 3'd3,
        CMD_BIST    = 3'd4
    } cmd_kind_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;

    localparam int unsigned WEIGHT_W = 3;

endpackage

// File: rtl/aer_sync_2ff.sv
module aer_sync_2ff #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                s_d = s_q;
                s_d.chain = async_i;
            end
        end else begin : g_many
            always_comb begin
                s_d = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/aer_addr_classify.sv
module aer_addr_classify
    import aer_dec_pkg::*;
#(
    parameter int unsigned NW = 8,
    localparam int unsigned AW = 2 * NW + 1
) (
    input  logic [AW-1:0]       addr_i,
    output cmd_kind_e           kind_o,
    output logic [NW-1:0]       src_o,
    output logic [NW-1:0]       dst_o,
    output logic [WEIGHT_W-1:0] weight_o,
    output logic                legal_o
);
    localparam logic [NW-1:0]          UP_ZERO  = '0;
    localparam logic [NW-1:0]          UP_TREF  = '1;
    localparam logic [NW-1:0]          UP_BIST  = {{(NW-1){1'b1}}, 1'b0};
    localparam logic [NW-WEIGHT_W-1:0] VIRT_PFX = {{(NW-WEIGHT_W-1){1'b0}}, 1'b1};

    logic          msb;
    logic [NW-1:0] upper;
    logic [NW-1:0] lower;
    logic          is_spike;
    logic          is_virt;
    logic          is_tref;
    logic          is_bist;

    always_comb begin
        msb   = addr_i[AW-1];
        upper = addr_i[2*NW-1:NW];
        lower = addr_i[NW-1:0];

        is_spike = !msb && (upper == UP_ZERO);
        is_virt  = !msb && (upper[NW-1:WEIGHT_W] == VIRT_PFX);
        is_tref  = !msb && (upper == UP_TREF) && (lower == '0);
        is_bist  = !msb && (upper == UP_BIST) && (lower == '0);

        kind_o   = CMD_SPIKE;
        src_o    = '0;
        dst_o    = '0;
        weight_o = '0;
        legal_o  = 1'b1;

        if (msb) begin
            kind_o = CMD_SYNAPSE;
            src_o  = upper;
            dst_o  = lower;
        end else if (is_spike) begin
            kind_o = CMD_SPIKE;
            src_o  = lower;
        end else if (is_virt) begin
            kind_o   = CMD_VIRTUAL;
            dst_o    = lower;
            weight_o = upper[WEIGHT_W-1:0];
        end else if (is_tref) begin
            kind_o = CMD_TREF;
        end else if (is_bist) begin
            kind_o = CMD_BIST;
        end else begin
            legal_o = 1'b0;
        end
    end

endmodule

// File: rtl/aer_cmd_slot.sv
module aer_cmd_slot
    import aer_dec_pkg::*;
#(
    parameter int unsigned NW = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                push_i,
    input  cmd_kind_e           kind_i,
    input  logic [NW-1:0]       src_i,
    input  logic [NW-1:0]       dst_i,
    input  logic [WEIGHT_W-1:0] weight_i,
    input  logic                ready_i,
    output logic                valid_o,
    output cmd_kind_e           kind_o,
    output logic [NW-1:0]       src_o,
    output logic [NW-1:0]       dst_o,
    output logic [WEIGHT_W-1:0] weight_o
);
    typedef struct packed {
        logic                valid;
        cmd_kind_e           kind;
        logic [NW-1:0]       src;
        logic [NW-1:0]       dst;
        logic [WEIGHT_W-1:0] weight;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.valid && ready_i) begin
            s_d.valid = 1'b0;
        end
        if (push_i && !s_q.valid) begin
            s_d.valid  = 1'b1;
            s_d.kind   = kind_i;
            s_d.src    = src_i;
            s_d.dst    = dst_i;
            s_d.weight = weight_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{valid: 1'b0, kind: CMD_SPIKE, src: '0, dst: '0, weight: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o  = s_q.valid;
    assign kind_o   = s_q.kind;
    assign src_o    = s_q.src;
    assign dst_o    = s_q.dst;
    assign weight_o = s_q.weight;

endmodule

// File: rtl/aer_event_decoder.sv
module aer_event_decoder
    import aer_dec_pkg::*;
#(
    parameter int unsigned N_NEURONS   = 256,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NW = $clog2(N_NEURONS),
    localparam int unsigned AW = 2 * NW + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                aer_req_i,
    input  logic [AW-1:0]       aer_addr_i,
    output logic                aer_ack_o,
    output logic                cmd_valid_o,
    input  logic                cmd_ready_i,
    output logic [2:0]          cmd_type_o,
    output logic [NW-1:0]       cmd_src_o,
    output logic [NW-1:0]       cmd_dst_o,
    output logic [WEIGHT_W-1:0] cmd_weight_o,
    output logic                err_o
);
    typedef struct packed {
        hs_state_e state;
        logic      ack;
        logic      err;
    } hs_t;

    hs_t h_d, h_q;

    logic                req_s;
    logic                capture;
    logic                push;
    cmd_kind_e           dec_kind;
    logic [NW-1:0]       dec_src;
    logic [NW-1:0]       dec_dst;
    logic [WEIGHT_W-1:0] dec_weight;
    logic                dec_legal;
    cmd_kind_e           slot_kind;

    aer_sync_2ff #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (aer_req_i),
        .sync_o  (req_s)
    );

    aer_addr_classify #(
        .NW (NW)
    ) u_classify (
        .addr_i   (aer_addr_i),
        .kind_o   (dec_kind),
        .src_o    (dec_src),
        .dst_o    (dec_dst),
        .weight_o (dec_weight),
        .legal_o  (dec_legal)
    );

    always_comb begin
        h_d     = h_q;
        capture = 1'b0;
        unique case (h_q.state)
            HS_IDLE: begin
                if (req_s && !cmd_valid_o) begin
                    capture  = 1'b1;
                    h_d.state = HS_ACK;
                    h_d.ack   = 1'b1;
                    if (!dec_legal) begin
                        h_d.err = 1'b1;
                    end
                end
            end
            HS_ACK: begin
                if (!req_s) begin
                    h_d.state = HS_IDLE;
                    h_d.ack   = 1'b0;
                end
            end
            default: begin
                h_d.state = HS_IDLE;
                h_d.ack   = 1'b0;
            end
        endcase
        push = capture && dec_legal;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            h_q <= '{state: HS_IDLE, ack: 1'b0, err: 1'b0};
        end else begin
            h_q <= h_d;
        end
    end

    aer_cmd_slot #(
        .NW (NW)
    ) u_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (push),
        .kind_i   (dec_kind),
        .src_i    (dec_src),
        .dst_i    (dec_dst),
        .weight_i (dec_weight),
        .ready_i  (cmd_ready_i),
        .valid_o  (cmd_valid_o),
        .kind_o   (slot_kind),
        .src_o    (cmd_src_o),
        .dst_o    (cmd_dst_o),
        .weight_o (cmd_weight_o)
    );

    assign cmd_type_o = slot_kind;
    assign aer_ack_o  = h_q.ack;
    assign err_o      = h_q.err;

endmodule

// File: rtl/aer_event_decoder_chk.sv
module aer_event_decoder_chk #(
    parameter int unsigned NW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_sync,
    input logic          aer_ack_o,
    input logic          cmd_valid_o,
    input logic          cmd_ready_i,
    input logic [2:0]    cmd_type_o,
    input logic [NW-1:0] cmd_src_o,
    input logic [NW-1:0] cmd_dst_o,
    input logic [2:0]    cmd_weight_o,
    input logic          err_o
);
    AST_ACK_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(aer_ack_o) |-> $past(req_sync)); // R1

    AST_ACK_FALL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(aer_ack_o) |-> !$past(req_sync)); // R1

    AST_CMD_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cmd_valid_o) |-> $rose(aer_ack_o)); // R2

    AST_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> (cmd_type_o <= 3'd4)); // R3

    AST_ERR_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> ($rose(aer_ack_o) && !cmd_valid_o)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o); // R8

    AST_NO_ACK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(aer_ack_o) |-> !$past(cmd_valid_o)); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_type_o)
            && $stable(cmd_src_o) && $stable(cmd_dst_o) && $stable(cmd_weight_o))); // R9

endmodule

bind aer_event_decoder aer_event_decoder_chk #(.NW(NW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_sync     (req_s),
    .aer_ack_o    (aer_ack_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_type_o   (cmd_type_o),
    .cmd_src_o    (cmd_src_o),
    .cmd_dst_o    (cmd_dst_o),
    .cmd_weight_o (cmd_weight_o),
    .err_o        (err_o)
);

// File: tb/sim_aer_event_decoder.sv
`timescale 1ns/1ps
module sim_aer_event_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [16:0] addr = '0;
    logic        ack;
    logic        cvalid;
    logic        cready = 1'b0;
    logic [2:0]  ctype;
    logic [7:0]  csrc;
    logic [7:0]  cdst;
    logic [2:0]  cw;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    aer_event_decoder u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .aer_req_i    (req),
        .aer_addr_i   (addr),
        .aer_ack_o    (ack),
        .cmd_valid_o  (cvalid),
        .cmd_ready_i  (cready),
        .cmd_type_o   (ctype),
        .cmd_src_o    (csrc),
        .cmd_dst_o    (cdst),
        .cmd_weight_o (cw),
        .err_o        (err)
    );

    // {addr[16:0], valid, type[2:0], src[7:0], dst[7:0], weight[2:0]}
    localparam logic [39:0] VEC [8] = '{
        {17'h0005A, 1'b1, 3'd0, 8'h5A, 8'h00, 3'd0},  // R3 spike
        {17'h000FF, 1'b1, 3'd0, 8'hFF, 8'h00, 3'd0},  // R3 spike top source
        {17'h11234, 1'b1, 3'd1, 8'h12, 8'h34, 3'd0},  // R4 synapse
        {17'h1FF00, 1'b1, 3'd1, 8'hFF, 8'h00, 3'd0},  // R4 synapse extremes
        {17'h00D80, 1'b1, 3'd2, 8'h00, 8'h80, 3'd5},  // R5 virtual weight 5
        {17'h00801, 1'b1, 3'd2, 8'h00, 8'h01, 3'd0},  // R5 virtual weight 0
        {17'h0FF00, 1'b1, 3'd3, 8'h00, 8'h00, 3'd0},  // R6 time reference
        {17'h0FE00, 1'b1, 3'd4, 8'h00, 8'h00, 3'd0}   // R7 bistability
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(input logic [16:0] a, input int exp_lat, input string tag);
        int lat = 0;
        @(negedge clk);
        addr = a;
        req  = 1'b1;
        while (!ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(ack == 1'b1, {tag, " R1 ack seen"}, 64'(ack), 64'd1);
        if (exp_lat > 0)
            check(lat == exp_lat, {tag, " R2 ack rise latency"}, 64'(lat), 64'(exp_lat));
    endtask

    task automatic drop(input string tag);
        int lat = 0;
        req = 1'b0;
        while (ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, {tag, " R2 ack fall latency"}, 64'(lat), 64'd3);
    endtask

    task automatic check_cmd(input logic [22:0] e, input string tag);
        logic [22:0] got;
        got = {cvalid, ctype, csrc, cdst, cw};
        check(got == e, tag, 64'(got), 64'(e));
    endtask

    task automatic consume;
        @(negedge clk);
        cready = 1'b1;
        @(negedge clk);
        cready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({ack, cvalid, err} == 3'b000, "R10 reset outputs", 64'({ack, cvalid, err}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({ack, cvalid, err} == 3'b000, "R10 after reset", 64'({ack, cvalid, err}), 64'd0);

        for (int i = 0; i < 8; i++) begin
            raise(VEC[i][39:23], 3, $sformatf("vec%0d", i));
            check_cmd(VEC[i][22:0], $sformatf("vec%0d R3 R4 R5 R6 R7 decode", i));
            drop($sformatf("vec%0d R1", i));
            consume();
            check(cvalid == 1'b0, $sformatf("vec%0d R9 consumed", i), 64'(cvalid), 64'd0);
            check(err == 1'b0, $sformatf("vec%0d R8 no error", i), 64'(err), 64'd0);
        end

        // R8: upper field just below the virtual prefix
        raise(17'h00101, 3, "R8 undefined a");
        check(cvalid == 1'b0, "R8 no command a", 64'(cvalid), 64'd0);
        check(err == 1'b1, "R8 error set a", 64'(err), 64'd1);
        drop("R8 a");
        // R8: time-reference code with a nonzero low byte
        raise(17'h0FF01, 3, "R8 undefined b");
        check(cvalid == 1'b0, "R8 no command b", 64'(cvalid), 64'd0);
        drop("R8 b");
        // R8: a legal word afterwards still decodes and the flag stays
        raise(17'h00077, 3, "R8 recovery");
        check_cmd({1'b1, 3'd0, 8'h77, 8'h00, 3'd0}, "R8 legal after error");
        check(err == 1'b1, "R8 error sticky", 64'(err), 64'd1);
        drop("R8 recovery");
        consume();

        // R9: back-pressure
        raise(17'h00033, 3, "R9 first");
        drop("R9 first");
        addr = 17'h1ABCD;
        repeat (2) @(negedge clk);
        check_cmd({1'b1, 3'd0, 8'h33, 8'h00, 3'd0}, "R9 fields hold on addr change");
        addr = 17'h1C3D4;
        req  = 1'b1;
        repeat (10) @(negedge clk);
        check(ack == 1'b0, "R9 no ack while pending", 64'(ack), 64'd0);
        check_cmd({1'b1, 3'd0, 8'h33, 8'h00, 3'd0}, "R9 pending command unchanged");
        cready = 1'b1;
        @(negedge clk);
        cready = 1'b0;
        begin
            int w = 0;
            while (!ack && w < 40) begin
                @(negedge clk);
                w++;
            end
        end
        check(ack == 1'b1, "R9 held request served", 64'(ack), 64'd1);
        check_cmd({1'b1, 3'd1, 8'hC3, 8'hD4, 3'd0}, "R9 second command R4");
        drop("R9 second");
        consume();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule